// File: doc/BRIEF.md
# Reserved-Address Identification Responder

This block sits behind an I2C target bit engine and answers the reserved identification address (7-bit 0x7C). The engine hands it one-cycle event pulses: START, repeated START, STOP, a received byte, and the master's ACK/NACK after each transmitted byte. The block returns an acknowledge request for each received byte and the next byte to shift out.

An identification read takes two phases. First, the master writes the reserved address, followed by one byte that carries the 7-bit address of the device it wants to query. Then, after a repeated START, the master reads from the reserved address. Only a responder whose own address matched in the first phase answers the read.

The identification word is built from four parameters: an 8-bit maker code, a 7-bit category, a 6-bit feature code and a 3-bit revision. This word is sent as three bytes. The sequence starts again from the first byte for as long as the master keeps acknowledging.

Top module: `dev_id_responder`

## Requirements
- R1: While `rst_ni` is low, `ack_o`, `tx_vld_o` and `tx_byte_o` are 0. Reset also cancels any handshake in progress, so a master ACK after reset produces no byte.
- R2: A first byte after START or repeated START equal to 0xF8 (reserved address, write bit 0) is acknowledged: `ack_o` is 1 the cycle after `byte_vld_i`.
- R3: The byte after 0xF8 is acknowledged only when bits [7:1] equal `own_addr_i`. Bit 0 is ignored. A match selects the responder.
- R4: When the responder is selected, a repeated START followed by 0xF9 (reserved address, read bit 1) is acknowledged. In the same cycle, `tx_vld_o` pulses with `tx_byte_o` equal to the maker code.
- R5: Each master ACK (`mack_i`=1) during the read produces a `tx_vld_o` pulse the next cycle. The bytes follow the 24-bit word {maker, category, feature, revision}: bits [23:16], then [15:8], then [7:0].
- R6: A master ACK after the third byte sends the first byte again, and the sequence keeps cycling.
- R7: A master NACK ends the read with no further byte and deselects the responder. A later repeated START with 0xF9 is not acknowledged.
- R8: A STOP followed by a new START cancels the selection, so a following 0xF9 is not acknowledged.
- R9: A repeated START followed by any address other than 0xF9 cancels the selection.
- R10: A non-matching query byte leaves the responder unselected, so a later 0xF9 is not acknowledged.
- R11: 0xF9 without a completed first phase is not acknowledged. Any address other than 0xF8 and 0xF9, including the responder's own, is never acknowledged.
- R12: `ack_o` pulses only in the cycle after a received byte. `tx_vld_o` pulses only in the cycle after a received byte or a master ACK. Stray data bytes and master ACKs outside a read produce neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | This responder's 7-bit bus address |
| start_i | input | 1 | START detected (pulse) |
| rstart_i | input | 1 | Repeated START detected (pulse) |
| stop_i | input | 1 | STOP detected (pulse) |
| byte_vld_i | input | 1 | Received byte valid (pulse) |
| byte_i | input | 8 | Received byte |
| mack_vld_i | input | 1 | Master acknowledge bit valid (pulse) |
| mack_i | input | 1 | 1 = master ACK, 0 = master NACK |
| ack_o | output | 1 | Acknowledge the byte just received (pulse) |
| tx_vld_o | output | 1 | Load `tx_byte_o` for transmission (pulse) |
| tx_byte_o | output | 8 | Next byte to transmit, MSB first |

## Verification
Every result is registered once. `ack_o` follows a received byte by one cycle, and `tx_vld_o` with `tx_byte_o` follows the byte or master ACK that triggered it by one cycle. The bench drives each event pulse on a falling edge and holds it for one cycle. It compares all three outputs on the next falling edge, after exactly one rising edge has captured the event. Event-only steps (START, STOP, repeated START) are also checked for silent outputs at that same point.

// File: rtl/dev_id_pkg.sv
package dev_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no handshake in progress
    ST_QUERY,  // reserved write seen, waiting for queried address
    ST_SEL,    // own address matched
    ST_ARMED,  // selected and repeated START seen
    ST_READ    // serving identification bytes
  } id_state_e;
endpackage

// File: rtl/dev_id_fsm.sv
module dev_id_fsm
  import dev_id_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter logic [6:0]  RSV_ADDR = 7'h7C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              start_i,
  input  logic              rstart_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              mack_vld_i,
  input  logic              mack_i,
  output logic              ack_o,
  output logic              load_o,
  output logic              adv_o,
  output logic              clr_o
);
  localparam logic [7:0] RSV_WR = {RSV_ADDR, 1'b0};
  localparam logic [7:0] RSV_RD = {RSV_ADDR, 1'b1};

  id_state_e st_q, st_d;
  logic      first_q, first_d;
  logic      ack_q, ack_d;

  always_comb begin
    st_d   = st_q;
    ack_d  = 1'b0;
    load_o = 1'b0;
    adv_o  = 1'b0;
    clr_o  = 1'b0;
    if (stop_i || start_i) begin
      st_d  = ST_IDLE;
      clr_o = 1'b1;
    end else if (rstart_i) begin
      if (st_q == ST_SEL) st_d = ST_ARMED;
      else begin
        st_d  = ST_IDLE;
        clr_o = 1'b1;
      end
    end else if (byte_vld_i) begin
      if (first_q && byte_i == RSV_WR) begin
        st_d  = ST_QUERY;
        ack_d = 1'b1;
        clr_o = 1'b1;
      end else if (first_q && byte_i == RSV_RD && st_q == ST_ARMED) begin
        st_d   = ST_READ;
        ack_d  = 1'b1;
        load_o = 1'b1;
      end else if (!first_q && st_q == ST_QUERY && byte_i[7:1] == own_addr_i) begin
        st_d  = ST_SEL;
        ack_d = 1'b1;
      end else begin
        st_d  = ST_IDLE;
        clr_o = 1'b1;
      end
    end else if (mack_vld_i && st_q == ST_READ) begin
      if (mack_i) adv_o = 1'b1;
      else begin
        st_d  = ST_IDLE;
        clr_o = 1'b1;
      end
    end
  end

  always_comb begin
    first_d = first_q;
    if (start_i || rstart_i)       first_d = 1'b1;
    else if (byte_vld_i || stop_i) first_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/dev_id_tx.sv
module dev_id_tx #(
  parameter int ID_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] id_word_i,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic            clr_i,
  output logic            tx_vld_o,
  output logic [7:0]      tx_byte_o
);
  localparam int NB    = ID_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic [7:0]       id_bytes [NB];
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             vld_q;
  logic [7:0]       byte_q;

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign id_bytes[g] = id_word_i[ID_W-1-8*g -: 8];
  end

  assign idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q <= load_i | adv_i;
      if (clr_i || load_i) idx_q <= '0;
      else if (adv_i)      idx_q <= idx_nxt;
      if (load_i)          byte_q <= id_bytes[0];
      else if (adv_i)      byte_q <= id_bytes[idx_nxt];
    end
  end

  assign tx_vld_o  = vld_q;
  assign tx_byte_o = byte_q;
endmodule

// File: rtl/dev_id_responder.sv
module dev_id_responder #(
  parameter logic [7:0] MAKER_ID = 8'hA5,
  parameter logic [6:0] CAT_ID   = 7'h2B,
  parameter logic [5:0] FEAT_ID  = 6'h19,
  parameter logic [2:0] REV_ID   = 3'h5,
  parameter logic [6:0] RSV_ADDR = 7'h7C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] own_addr_i,
  input  logic       start_i,
  input  logic       rstart_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       mack_vld_i,
  input  logic       mack_i,
  output logic       ack_o,
  output logic       tx_vld_o,
  output logic [7:0] tx_byte_o
);
  localparam int ID_W = $bits(MAKER_ID) + $bits(CAT_ID) + $bits(FEAT_ID) + $bits(REV_ID);
  localparam logic [ID_W-1:0] ID_WORD = {MAKER_ID, CAT_ID, FEAT_ID, REV_ID};

  logic load, adv, clr;

  dev_id_fsm #(.ADDR_W(7), .RSV_ADDR(RSV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .own_addr_i, .start_i, .rstart_i, .stop_i,
    .byte_vld_i, .byte_i, .mack_vld_i, .mack_i,
    .ack_o, .load_o(load), .adv_o(adv), .clr_o(clr)
  );

  dev_id_tx #(.ID_W(ID_W)) u_tx (
    .clk_i, .rst_ni, .id_word_i(ID_WORD),
    .load_i(load), .adv_i(adv), .clr_i(clr),
    .tx_vld_o, .tx_byte_o
  );
endmodule

// File: rtl/dev_id_responder_chk.sv
module dev_id_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [6:0] own_addr_i,
  input logic       start_i,
  input logic       rstart_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic       mack_vld_i,
  input logic       mack_i,
  input logic       ack_o,
  input logic       tx_vld_o,
  input logic [7:0] tx_byte_o
);
  always @(posedge clk_i)
    if (!rst_ni) p_reset_quiet_r1: assert (!ack_o && !tx_vld_o && tx_byte_o == 8'h00);

  p_ack_after_byte_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_vld_i));

  p_tx_after_event_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(byte_vld_i || mack_vld_i));

  p_ack_advances_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_vld_o && $past(mack_vld_i)) |-> $past(mack_i));

  p_nack_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mack_vld_i && !mack_i) |=> !tx_vld_o);

  p_stop_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!ack_o && !tx_vld_o));
endmodule

bind dev_id_responder dev_id_responder_chk u_chk (.*);

// File: tb/dev_id_responder_tb.sv
module dev_id_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_ST = 3'd0, K_RS = 3'd1, K_SP = 3'd2, K_BY = 3'd3, K_MA = 3'd4;
  localparam int NV = 42;
  // {req[3:0], kind[2:0], data[7:0], exp_ack, exp_tx, exp_byte[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd2,  K_BY, 8'hF8, 1'b1, 1'b0, 8'h00},  // R2
    {4'd3,  K_BY, 8'h41, 1'b1, 1'b0, 8'h00},  // R3 lsb ignored
    {4'd4,  K_RS, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd4,  K_BY, 8'hF9, 1'b1, 1'b1, 8'hA5},  // R4
    {4'd5,  K_MA, 8'h01, 1'b0, 1'b1, 8'h56},  // R5
    {4'd5,  K_MA, 8'h01, 1'b0, 1'b1, 8'hCD},
    {4'd6,  K_MA, 8'h01, 1'b0, 1'b1, 8'hA5},  // R6 wrap
    {4'd6,  K_MA, 8'h01, 1'b0, 1'b1, 8'h56},
    {4'd7,  K_MA, 8'h00, 1'b0, 1'b0, 8'h00},  // R7 nack
    {4'd7,  K_RS, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd7,  K_BY, 8'hF9, 1'b0, 1'b0, 8'h00},
    {4'd8,  K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd8,  K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd2,  K_BY, 8'hF8, 1'b1, 1'b0, 8'h00},
    {4'd3,  K_BY, 8'h40, 1'b1, 1'b0, 8'h00},
    {4'd8,  K_SP, 8'h00, 1'b0, 1'b0, 8'h00},  // R8
    {4'd8,  K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd8,  K_BY, 8'hF9, 1'b0, 1'b0, 8'h00},
    {4'd8,  K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd9,  K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd2,  K_BY, 8'hF8, 1'b1, 1'b0, 8'h00},
    {4'd3,  K_BY, 8'h40, 1'b1, 1'b0, 8'h00},
    {4'd9,  K_RS, 8'h00, 1'b0, 1'b0, 8'h00},  // R9
    {4'd9,  K_BY, 8'h42, 1'b0, 1'b0, 8'h00},
    {4'd9,  K_RS, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd9,  K_BY, 8'hF9, 1'b0, 1'b0, 8'h00},
    {4'd9,  K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd10, K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd2,  K_BY, 8'hF8, 1'b1, 1'b0, 8'h00},
    {4'd10, K_BY, 8'h44, 1'b0, 1'b0, 8'h00},  // R10
    {4'd10, K_RS, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd10, K_BY, 8'hF9, 1'b0, 1'b0, 8'h00},
    {4'd10, K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd11, K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd11, K_BY, 8'hF9, 1'b0, 1'b0, 8'h00},  // R11
    {4'd11, K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd11, K_ST, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd11, K_BY, 8'h40, 1'b0, 1'b0, 8'h00},
    {4'd11, K_SP, 8'h00, 1'b0, 1'b0, 8'h00},
    {4'd12, K_MA, 8'h01, 1'b0, 1'b0, 8'h00},  // R12
    {4'd12, K_BY, 8'h55, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rstart = 0, stop = 0, bvld = 0, mvld = 0, mack = 0;
  logic [7:0] bdat = '0;
  logic ack, txv;
  logic [7:0] txb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_id_responder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(7'h20),
    .start_i(start), .rstart_i(rstart), .stop_i(stop),
    .byte_vld_i(bvld), .byte_i(bdat), .mack_vld_i(mvld), .mack_i(mack),
    .ack_o(ack), .tx_vld_o(txv), .tx_byte_o(txb)
  );

  task automatic check(input int req, input logic ea, input logic et, input logic [7:0] eb);
    logic [9:0] act, exp;
    act = {ack, txv, et ? txb : 8'h00};
    exp = {ea, et, eb};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d ack/tx/byte actual=%b/%b/%h expected=%b/%b/%h",
               req, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [7:0] d);
    start  = (k == K_ST);
    rstart = (k == K_RS);
    stop   = (k == K_SP);
    bvld   = (k == K_BY);
    mvld   = (k == K_MA);
    bdat   = d;
    mack   = d[0];
    @(negedge clk);
    {start, rstart, stop, bvld, mvld} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0, 8'h00);  // R1 outputs quiet in reset
    if (txb !== 8'h00) begin checks++; fails++; $display("FAIL R1 tx_byte actual=%h expected=00", txb); end
    else checks++;
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20:18], VEC[i][17:10]);
      check(int'(VEC[i][24:21]), VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end
    // R1: reset in the middle of a read cancels the handshake
    step(K_ST, 8'h00); check(1, 1'b0, 1'b0, 8'h00);
    step(K_BY, 8'hF8); check(2, 1'b1, 1'b0, 8'h00);
    step(K_BY, 8'h40); check(3, 1'b1, 1'b0, 8'h00);
    step(K_RS, 8'h00); check(4, 1'b0, 1'b0, 8'h00);
    step(K_BY, 8'hF9); check(4, 1'b1, 1'b1, 8'hA5);
    rst_n = 1'b0;
    #1 check(1, 1'b0, 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    step(K_MA, 8'h01); check(1, 1'b0, 1'b0, 8'h00);
    // R5 fresh read after a NACK midway through a second session
    step(K_ST, 8'h00); step(K_BY, 8'hF8); step(K_BY, 8'h41);
    step(K_RS, 8'h00);
    step(K_BY, 8'hF9); check(5, 1'b1, 1'b1, 8'hA5);
    step(K_MA, 8'h01); check(5, 1'b0, 1'b1, 8'h56);
    step(K_MA, 8'h00); check(7, 1'b0, 1'b0, 8'h00);
    step(K_SP, 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule